// File: doc/BRIEF.md
# Next-Instruction Field Alteration Unit

This unit serves an alter instruction in a pipeline of 32-bit instruction words. Each word carries a 4-bit condition in bits 31:28, a 7-bit opcode in 27:21, the C, Z and I flags in bits 20, 19 and 18, a 9-bit destination field in 17:9 and a 9-bit source field in 8:0. The alter instruction supplies a register value D and a 9-bit pattern S. S holds three 3-bit codes: the result code in S[8:6], the destination code in S[5:3] and the source code in S[2:0]. From these the unit does two things. It computes a new D to write back. It also arms override controls that rewrite fields of the one instruction that follows, only as that instruction passes through the pipeline.

The pipeline presents the following instruction on `in_instr` and receives the rewritten word on `out_instr`. It also receives a flag that cancels that instruction's result write, and an optional replacement result register address. Indirect and auto-indexed register addressing are each one alter instruction placed in front of an ordinary instruction. The caller supplies the S pattern, so one unit covers pointer walks in either direction and through either field.

Top module: `field_alter_unit`

## Requirements
- R1: Destination code values 000, 001, 010 and 011 (S[5:3]) leave D[17:9] unchanged, load it with D[8:0], subtract one from it, or add one to it, in that order. The arithmetic wraps modulo 512 and never touches D[27:19].
- R2: Destination code values 1xx change D[17:9] as in R1 using their low two bits. They also arm a substitution that puts the value D[17:9] had before the change into bits 17:9 of the next instruction.
- R3: The source code S[2:0] acts on D[8:0] in the same way. Code 001 loads the field from D[17:9], 010 and 011 wrap modulo 512 without carry into D[17:9], and 1xx substitutes the unchanged D[8:0] into bits 8:0 of the next instruction.
- R4: Result code 001 (S[8:6]) raises `out_cancel_wr` while the next instruction is presented, and leaves D[31:18] unchanged.
- R5: Result codes 010 and 011 subtract one from or add one to the 9-bit field D[27:19], wrapping modulo 512 with no carry into D[31:28] or D[18].
- R6: Result code 100 raises `out_res_sel` with `out_res_addr` equal to D[27:19]. Codes 110 and 111 do the same with the value before the change, and write back D[27:19] minus one or plus one.
- R7: Result code 101 replaces bits 31:18 of the next instruction with D[31:18]. D is written back with those bits unchanged.
- R8: `wb_valid` equals `alt_valid`, and `wb_data` holds the modified D in that same cycle, whether or not a substitution is armed. D[31:28] and D[18] are never modified.
- R9: After an alter instruction is accepted, `ovr_armed` is high from the next cycle. It stays high until the edge at which `next_issue` is sampled high, and then clears, so the overrides apply to exactly one instruction.
- R10: `flush` clears any armed override at the next edge. A flush in the same cycle as `alt_valid` leaves nothing armed.
- R11: While nothing is armed, `out_instr` equals `in_instr`, and `out_cancel_wr`, `out_res_sel` and `out_res_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_valid | input | 1 | An alter instruction completes this cycle |
| alt_d | input | 32 | Register value D of the alter instruction |
| alt_s | input | 9 | Pattern S: result, destination and source codes |
| next_issue | input | 1 | The following instruction issues this cycle |
| flush | input | 1 | Pipeline flush; drops any armed override |
| in_instr | input | 32 | Following instruction word as fetched |
| wb_valid | output | 1 | Write-back strobe for the modified D |
| wb_data | output | 32 | Modified D |
| out_instr | output | 32 | Following instruction with substitutions applied |
| out_cancel_wr | output | 1 | Suppress the following instruction's result write |
| out_res_sel | output | 1 | Use `out_res_addr` as the result register |
| out_res_addr | output | 9 | Replacement result register address |
| ovr_armed | output | 1 | An override is pending for the next instruction |

## Verification
A wrong field step shows at `wb_data` in the same cycle as the alter instruction, because write-back is combinational. Values one step off, a copy from the wrong field, or a carry leaking across a field boundary can be seen there at once. A wrong captured override shows one cycle later, when the next instruction is presented on `in_instr`. It appears as a field substituted from the modified D instead of the original, or as the wrong cancel or result-select flag. A disarm that does not happen shows in the cycle after issue or flush, when `out_instr` fails to pass `in_instr` through unchanged.

// File: rtl/fau_pkg.sv
// Shared field layout, pattern codes and types for the alteration unit.
// Assumes the fixed 32-bit instruction layout described in the brief.
package fau_pkg;
    localparam int WORD_W   = 32;
    localparam int FLD_W    = 9;
    localparam int SRC_LSB  = 0;
    localparam int DST_LSB  = SRC_LSB + FLD_W;
    localparam int IMM_BIT  = DST_LSB + FLD_W;      // 18
    localparam int OCZ_LSB  = IMM_BIT + 1;          // 19
    localparam int COND_LSB = OCZ_LSB + FLD_W;      // 28
    localparam int HEAD_W   = WORD_W - IMM_BIT;     // 14 bits: cond..I

    typedef logic [FLD_W-1:0] fld_t;

    // Per-field step operation (low two bits of a 3-bit code)
    typedef enum logic [1:0] {
        STEP_KEEP = 2'b00,
        STEP_COPY = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_INC  = 2'b11
    } step_e;

    // Result group codes
    localparam logic [2:0] RC_NONE    = 3'b000;
    localparam logic [2:0] RC_NOWR    = 3'b001;
    localparam logic [2:0] RC_DEC     = 3'b010;
    localparam logic [2:0] RC_INC     = 3'b011;
    localparam logic [2:0] RC_USE     = 3'b100;
    localparam logic [2:0] RC_HEAD    = 3'b101;
    localparam logic [2:0] RC_USE_DEC = 3'b110;
    localparam logic [2:0] RC_USE_INC = 3'b111;

    // Captured override state for the following instruction
    typedef struct packed {
        logic cancel;
        logic use_res;
        logic head;
        logic dsub;
        logic ssub;
    } ovr_t;
endpackage

// File: rtl/fau_field_step.sv
// One 9-bit field step: keep, copy from partner field, wrap-decrement
// or wrap-increment. Assumes arithmetic stays inside the field width.
module fau_field_step
    import fau_pkg::*;
#(
    parameter int W = FLD_W
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] partner,
    input  logic [1:0]   op,
    output logic [W-1:0] nxt
);
    // Select the new field value from the step code
    always_comb begin
        unique case (step_e'(op))
            STEP_KEEP: nxt = own;
            STEP_COPY: nxt = partner;
            STEP_DEC:  nxt = own - W'(1);
            STEP_INC:  nxt = own + W'(1);
            default:   nxt = own;
        endcase
    end
endmodule

// File: rtl/fau_res_decode.sv
// Decodes the 3-bit result code into a step for the opcode+C+Z field
// and the override flags it arms. Pure combinational.
module fau_res_decode
    import fau_pkg::*;
(
    input  logic [2:0] rcode,
    output logic [1:0] step_op,
    output logic       cancel,
    output logic       use_res,
    output logic       head
);
    // Map each result code to a field step and override flags
    always_comb begin
        step_op = STEP_KEEP;
        cancel  = 1'b0;
        use_res = 1'b0;
        head    = 1'b0;
        unique case (rcode)
            RC_NONE:    ;
            RC_NOWR:    cancel = 1'b1;
            RC_DEC:     step_op = STEP_DEC;
            RC_INC:     step_op = STEP_INC;
            RC_USE:     use_res = 1'b1;
            RC_HEAD:    head = 1'b1;
            RC_USE_DEC: begin use_res = 1'b1; step_op = STEP_DEC; end
            RC_USE_INC: begin use_res = 1'b1; step_op = STEP_INC; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/fau_override_reg.sv
// Holds the override flags and the unmodified D for exactly one
// following instruction. Flush beats load; load beats consume.
module fau_override_reg
    import fau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic              consume,
    input  ovr_t              load_ovr,
    input  logic [WORD_W-1:0] load_d,
    output logic              armed,
    output ovr_t              ovr,
    output logic [WORD_W-1:0] saved_d
);
    // Arm on an accepted alter, disarm on issue or flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            ovr     <= '0;
            saved_d <= '0;
        end else if (flush) begin
            armed   <= 1'b0;
            ovr     <= '0;
        end else if (load) begin
            armed   <= 1'b1;
            ovr     <= load_ovr;
            saved_d <= load_d;
        end else if (consume) begin
            armed   <= 1'b0;
            ovr     <= '0;
        end
    end

    AST_ARM_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> armed); // R9
endmodule

// File: rtl/field_alter_unit.sv
// Next-instruction field alteration unit. Computes the modified D of an
// alter instruction combinationally, and arms pipeline-only overrides
// for the one instruction that follows. Assumes the pipeline raises
// next_issue exactly when that following instruction leaves this stage.
module field_alter_unit
    import fau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_valid,
    input  logic [WORD_W-1:0] alt_d,
    input  logic [FLD_W-1:0]  alt_s,
    input  logic              next_issue,
    input  logic              flush,
    input  logic [WORD_W-1:0] in_instr,
    output logic              wb_valid,
    output logic [WORD_W-1:0] wb_data,
    output logic [WORD_W-1:0] out_instr,
    output logic              out_cancel_wr,
    output logic              out_res_sel,
    output logic [FLD_W-1:0]  out_res_addr,
    output logic              ovr_armed
);
    localparam int GRP_W = 3;

    logic [GRP_W-1:0] rcode, dcode, scode;
    logic [1:0]       ocz_op;
    logic             dec_cancel, dec_use, dec_head;
    fld_t             new_fld [2];   // [0] source, [1] destination
    fld_t             new_ocz;
    ovr_t             load_ovr, ovr;
    logic [WORD_W-1:0] saved_d;

    assign rcode = alt_s[8:6];
    assign dcode = alt_s[5:3];
    assign scode = alt_s[2:0];

    fau_res_decode u_rdec (
        .rcode   (rcode),
        .step_op (ocz_op),
        .cancel  (dec_cancel),
        .use_res (dec_use),
        .head    (dec_head)
    );

    // Source (g=0) and destination (g=1) field steppers
    for (genvar g = 0; g < 2; g++) begin : g_fld
        fau_field_step #(.W(FLD_W)) u_step (
            .own     (alt_d[SRC_LSB + g*FLD_W +: FLD_W]),
            .partner (alt_d[SRC_LSB + (1-g)*FLD_W +: FLD_W]),
            .op      ((g == 1) ? dcode[1:0] : scode[1:0]),
            .nxt     (new_fld[g])
        );
    end

    fau_field_step #(.W(FLD_W)) u_ocz (
        .own     (alt_d[OCZ_LSB +: FLD_W]),
        .partner (alt_d[OCZ_LSB +: FLD_W]),
        .op      (ocz_op),
        .nxt     (new_ocz)
    );

    // Assemble the written-back D; condition and I bits pass untouched
    always_comb begin
        wb_valid = alt_valid;
        wb_data  = {alt_d[WORD_W-1:COND_LSB], new_ocz, alt_d[IMM_BIT],
                    new_fld[1], new_fld[0]};
    end

    // Gather the override flags to capture with the alter instruction
    always_comb begin
        load_ovr.cancel  = dec_cancel;
        load_ovr.use_res = dec_use;
        load_ovr.head    = dec_head;
        load_ovr.dsub    = dcode[2];
        load_ovr.ssub    = scode[2];
    end

    fau_override_reg u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .load     (alt_valid),
        .consume  (next_issue),
        .load_ovr (load_ovr),
        .load_d   (alt_d),
        .armed    (ovr_armed),
        .ovr      (ovr),
        .saved_d  (saved_d)
    );

    // Rewrite the following instruction from the unmodified D
    always_comb begin
        out_instr     = in_instr;
        out_cancel_wr = 1'b0;
        out_res_sel   = 1'b0;
        out_res_addr  = '0;
        if (ovr_armed) begin
            if (ovr.head)
                out_instr[WORD_W-1:IMM_BIT] = saved_d[WORD_W-1:IMM_BIT];
            if (ovr.dsub)
                out_instr[DST_LSB +: FLD_W] = saved_d[DST_LSB +: FLD_W];
            if (ovr.ssub)
                out_instr[SRC_LSB +: FLD_W] = saved_d[SRC_LSB +: FLD_W];
            out_cancel_wr = ovr.cancel;
            if (ovr.use_res) begin
                out_res_sel  = 1'b1;
                out_res_addr = saved_d[OCZ_LSB +: FLD_W];
            end
        end
    end

    AST_WB_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid == alt_valid); // R8
    AST_WB_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        alt_valid |-> (wb_data[31:28] == alt_d[31:28] && wb_data[18] == alt_d[18])); // R8
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_armed && next_issue && !alt_valid && !flush) |=> !ovr_armed); // R9
    AST_FLUSH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ovr_armed); // R10
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_armed |-> (out_instr == in_instr && !out_cancel_wr && !out_res_sel)); // R11
    AST_CANCEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_cancel_wr && out_res_sel)); // R4
endmodule

// File: tb/field_alter_unit_bench.sv
module field_alter_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_valid = 1'b0;
    logic [31:0] alt_d = '0;
    logic [8:0]  alt_s = '0;
    logic        next_issue = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] in_instr = '0;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic [31:0] out_instr;
    logic        out_cancel_wr;
    logic        out_res_sel;
    logic [8:0]  out_res_addr;
    logic        ovr_armed;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    field_alter_unit u_field_alter_unit (
        .clk(clk), .rst_n(rst_n), .alt_valid(alt_valid), .alt_d(alt_d),
        .alt_s(alt_s), .next_issue(next_issue), .flush(flush),
        .in_instr(in_instr), .wb_valid(wb_valid), .wb_data(wb_data),
        .out_instr(out_instr), .out_cancel_wr(out_cancel_wr),
        .out_res_sel(out_res_sel), .out_res_addr(out_res_addr),
        .ovr_armed(ovr_armed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] step9(input logic [8:0] own, input logic [8:0] oth,
                                         input logic [1:0] op);
        case (op)
            2'd0: return own;
            2'd1: return oth;
            2'd2: return own - 9'd1;
            default: return own + 9'd1;
        endcase
    endfunction

    // Expected write-back built from the requirement text
    function automatic logic [31:0] model_wb(input logic [31:0] d, input logic [8:0] s);
        logic [8:0] ocz = d[27:19];
        logic [8:0] nd  = step9(d[17:9], d[8:0], s[4:3]);
        logic [8:0] ns  = step9(d[8:0], d[17:9], s[1:0]);
        if (s[8:6] == 3'b010 || s[8:6] == 3'b110) ocz = ocz - 9'd1;
        if (s[8:6] == 3'b011 || s[8:6] == 3'b111) ocz = ocz + 9'd1;
        return {d[31:28], ocz, d[18], nd, ns};
    endfunction

    // Present an alter instruction, check same-cycle write-back, arm at edge
    task automatic do_alter(input logic [31:0] d, input logic [8:0] s, input string req);
        @(negedge clk);
        alt_valid = 1'b1; alt_d = d; alt_s = s;
        #1;
        chk({req, " R8 wb_valid"}, 32'(wb_valid), 32'd1);
        chk({req, " wb_data"}, wb_data, model_wb(d, s));
        @(negedge clk);
        alt_valid = 1'b0;
        #1;
        chk({req, " R9 armed"}, 32'(ovr_armed), 32'd1);
        chk({req, " R8 wb_valid low"}, 32'(wb_valid), 32'd0);
    endtask

    // Present the next instruction, check overrides, then issue it
    task automatic next_instr(input logic [31:0] ins, input logic [31:0] exp_ins,
                              input logic exp_cancel, input logic exp_sel,
                              input logic [8:0] exp_addr, input string req);
        in_instr = ins;
        #1;
        chk({req, " out_instr"}, out_instr, exp_ins);
        chk({req, " cancel"}, 32'(out_cancel_wr), 32'(exp_cancel));
        chk({req, " res_sel"}, 32'(out_res_sel), 32'(exp_sel));
        chk({req, " res_addr"}, 32'(out_res_addr), 32'(exp_addr));
        next_issue = 1'b1;
        @(negedge clk);
        next_issue = 1'b0;
        #1;
        chk("R9 disarm after issue", 32'(ovr_armed), 32'd0);
        chk("R11 passthrough after issue", out_instr, ins);
    endtask

    task automatic t_reset();
        in_instr = 32'hA5A5_1234;
        #1;
        chk("R11 reset armed", 32'(ovr_armed), 32'd0);
        chk("R11 reset passthrough", out_instr, 32'hA5A5_1234);
        chk("R11 reset cancel", 32'(out_cancel_wr), 32'd0);
        chk("R11 reset res_sel", 32'(out_res_sel), 32'd0);
    endtask

    task automatic t_dest_modes();
        // R1: dest 0 decrement wraps to 0x1FF, opcode field untouched
        do_alter({4'h3, 9'h0AA, 1'b1, 9'h000, 9'h055}, 9'b000_010_000, "R1 dec wrap");
        next_instr(32'h1111_1111, 32'h1111_1111, 1'b0, 1'b0, 9'h0, "R1 no subst");
        do_alter({4'h3, 9'h0AA, 1'b0, 9'h010, 9'h0C3}, 9'b000_001_000, "R1 copy");
        next_instr(32'h2222_2222, 32'h2222_2222, 1'b0, 1'b0, 9'h0, "R1 no subst");
        do_alter({4'h0, 9'h1FF, 1'b0, 9'h1FF, 9'h000}, 9'b000_011_000, "R1 inc wrap");
        next_instr(32'h0, 32'h0, 1'b0, 1'b0, 9'h0, "R1 no subst");
    endtask

    task automatic t_dest_subst();
        logic [31:0] d = {4'h7, 9'h101, 1'b0, 9'h0F0, 9'h00F};
        do_alter(d, 9'b000_111_000, "R2 subst+inc");
        next_instr(32'hFFFF_FFFF, {14'h3FFF, 9'h0F0, 9'h1FF}, 1'b0, 1'b0, 9'h0, "R2 dest pre-value");
    endtask

    task automatic t_src_modes();
        logic [31:0] d = {4'h1, 9'h022, 1'b1, 9'h013, 9'h1FF};
        do_alter(d, 9'b000_000_011, "R3 inc wrap");
        next_instr(32'h0, 32'h0, 1'b0, 1'b0, 9'h0, "R3 no subst");
        do_alter(d, 9'b000_000_101, "R3 subst+copy");
        next_instr(32'h0, {14'h0, 9'h000, 9'h1FF}, 1'b0, 1'b0, 9'h0, "R3 src pre-value");
        do_alter(d, 9'b000_000_010, "R3 dec");
        next_instr(32'h0, 32'h0, 1'b0, 1'b0, 9'h0, "R3 no subst");
    endtask

    task automatic t_cancel();
        do_alter(32'hDEAD_BEEF, 9'b001_000_000, "R4 cancel");
        next_instr(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 9'h0, "R4 cancel flag");
    endtask

    task automatic t_ocz_step();
        do_alter({4'h5, 9'h1FF, 1'b0, 9'h000, 9'h000}, 9'b011_000_000, "R5 inc wrap");
        next_instr(32'h0, 32'h0, 1'b0, 1'b0, 9'h0, "R5 no override");
        do_alter({4'h5, 9'h000, 1'b1, 9'h1FF, 9'h1FF}, 9'b010_000_000, "R5 dec wrap");
        next_instr(32'h0, 32'h0, 1'b0, 1'b0, 9'h0, "R5 no override");
    endtask

    task automatic t_result_reg();
        do_alter({4'h2, 9'h040, 1'b0, 9'h001, 9'h002}, 9'b110_000_000, "R6 use+dec");
        next_instr(32'h0, 32'h0, 1'b0, 1'b1, 9'h040, "R6 use pre-value");
        do_alter({4'h2, 9'h1FF, 1'b0, 9'h001, 9'h002}, 9'b111_000_000, "R6 use+inc");
        next_instr(32'h0, 32'h0, 1'b0, 1'b1, 9'h1FF, "R6 use pre-value");
        do_alter({4'h2, 9'h033, 1'b0, 9'h001, 9'h002}, 9'b100_000_000, "R6 use");
        next_instr(32'h0, 32'h0, 1'b0, 1'b1, 9'h033, "R6 use only");
    endtask

    task automatic t_head();
        logic [31:0] d = {4'hC, 9'h155, 1'b1, 9'h0AB, 9'h0CD};
        do_alter(d, 9'b101_000_000, "R7 head");
        next_instr(32'h0000_0000, {d[31:18], 18'h0}, 1'b0, 1'b0, 9'h0, "R7 head replace");
    endtask

    task automatic t_flush();
        do_alter(32'h0000_0000, 9'b001_100_100, "R10 arm");
        @(negedge clk);
        // ovr still armed without issue; now flush
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        in_instr = 32'h5555_AAAA;
        #1;
        chk("R10 flush disarm", 32'(ovr_armed), 32'd0);
        chk("R10 flush passthrough", out_instr, 32'h5555_AAAA);
        chk("R10 flush cancel", 32'(out_cancel_wr), 32'd0);
        // flush together with alt_valid
        @(negedge clk);
        alt_valid = 1'b1; alt_d = 32'hFFFF_FFFF; alt_s = 9'b101_100_100; flush = 1'b1;
        @(negedge clk);
        alt_valid = 1'b0; flush = 1'b0;
        #1;
        chk("R10 flush beats alter", 32'(ovr_armed), 32'd0);
        chk("R11 idle after flush", out_instr, 32'h5555_AAAA);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
            begin
                repeat (2) @(negedge clk);
                t_reset();
                @(negedge clk);
                rst_n = 1'b1;
                t_dest_modes();
                t_dest_subst();
                t_src_modes();
                t_cancel();
                t_ocz_step();
                t_result_reg();
                t_head();
                t_flush();
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule